// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a 16-bit interval timer with a small register bus. When running in timer mode it counts down once every 2 or 8 system clock cycles. A built-in prescaler makes these ticks. When the count steps down from zero, the block raises an underflow event flag. It then either restarts from a programmable reload value or wraps to all ones. Software can stop the timer and restart it. It can also copy the reload value into the counter, or zero the counter, by writing single strobe bits in the control word.

An external input line is synchronised into the clock domain. It can be used in two ways. It can zero the counter on a chosen edge, or it can gate the count ticks by its level. Event flags are cleared by writing zero to them, and writing one to them has no effect. An interrupt output reports each flag that has its enable set.

Top module: `reload_updown_timer`

## Requirements
- R1: After reset, the counter, the reload value, the status word and the interrupt output are all zero. The control word reads 0x0008.
- R2: Counting runs when status bit 7 (run) is 1 and control bits 11:10 are 00 (timer mode). The counter then drops by one every D cycles. D is 8 when control bit 12 is 1 and 2 when it is 0. The first decrement comes D cycles after the write that sets run.
- R3: A decrement from 0x0000 is an underflow. It sets status bit 2. The counter then takes the reload value if control bit 4 is 1, and 0xFFFF if it is 0.
- R4: The reload value is written one byte at a time. Address 2 holds the low byte and address 3 the high byte (data bits 7:0). Both read back zero-extended. The counter reads at address 4, the control word at address 0 and the status word at address 1.
- R5: Writing the control word with bit 6 set copies the reload value into the counter on the next cycle. With bit 6 clear it leaves the counter alone. Bit 6 always reads 0.
- R6: Writing the control word with bit 3 clear zeroes the counter. With bit 3 set it leaves the counter alone. Bit 3 always reads 1. When one write has both bit 6 set and bit 3 clear, the copy wins.
- R7: Status bit 2 and control bit 14 are cleared by writing 0 and are unchanged by writing 1. An underflow in the same cycle as a clearing write leaves status bit 2 set. Control bit 14 is never set in timer mode.
- R8: The interrupt output is high exactly when status bit 2 and status bit 5 are both 1, or when control bits 14 and 13 are both 1.
- R9: Clear use of the external input needs control bit 2 at 0 and control bit 5 at 1. Control bits 1:0 then select the edge that zeroes the counter: 01 rising, 10 falling, 11 both, 00 none. The input passes through two synchroniser flops first.
- R10: With control bit 2 at 1, the external input gates the decrements. Code 01 allows them only while the input is high, 10 only while it is low, and 00 or 11 never blocks them.
- R11: With run at 0, or with control bits 11:10 not 00, the counter holds its value.
- R12: Control bits 15, 13, 12, 11:8, 7, 5, 4 and 2:0 read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| ext_in | input | 1 | External clear or gate line |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a write that clears the underflow flag landing on the same clock edge as an underflow. Here the set must win. The bench loads a zero count with the fast prescaler selected and starts the timer. It then times a status write so that it is captured exactly two cycles later, on the underflow edge. Separately, a sweep over prescaler choice, reload enable, start values and tick counts checks the exact count, flag and interrupt each time against an arithmetic model.

// File: rtl/rut_pkg.sv
package rut_pkg;
  localparam int CNT_W  = 16;
  localparam int HALF_W = CNT_W / 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;

  // control word bit positions
  localparam int C_REV_FLAG = 14;
  localparam int C_REV_IE   = 13;
  localparam int C_CLK_SLOW = 12;
  localparam int C_MODE_LO  = 10;
  localparam int C_LOAD     = 6;
  localparam int C_XCLR_EN  = 5;
  localparam int C_RLD_EN   = 4;
  localparam int C_CLR_N    = 3;
  localparam int C_GATE_SEL = 2;
  localparam int C_EDGE_LO  = 0;

  // status word bit positions
  localparam int S_RUN   = 7;
  localparam int S_UF_IE = 5;
  localparam int S_UF    = 2;

  // bits of the control word held as plain storage
  localparam logic [CNT_W-1:0] CTRL_KEEP = 16'hBFB7;

  // one down step: {underflow, next value}
  function automatic logic [CNT_W:0] count_step(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] rld,
                                                input logic             rld_en);
    if (cur == '0)
      return {1'b1, (rld_en ? rld : {CNT_W{1'b1}})};
    return {1'b0, cur - CNT_W'(1)};
  endfunction

  function automatic logic edge_hit(input logic prev, input logic cur,
                                    input logic [1:0] sel);
    case (sel)
      2'b01:   return !prev && cur;
      2'b10:   return prev && !cur;
      2'b11:   return prev != cur;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic gate_open(input logic lvl, input logic [1:0] sel);
    case (sel)
      2'b01:   return lvl;
      2'b10:   return !lvl;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/rut_prescaler.sv
module rut_prescaler #(
  parameter int SLOW_DIV = 8,
  parameter int FAST_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int PW = $clog2(SLOW_DIV);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  assign lim  = slow ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
  assign tick = run && (pre_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/rut_ext_input.sv
module rut_ext_input
  import rut_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_in,
  input  logic       gate_sel,
  input  logic       clr_en,
  input  logic [1:0] edge_sel,
  output logic       clear_evt,
  output logic       gate_ok
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            lvl;

  assign lvl = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], ext_in};
      prev_q <= lvl;
    end
  end

  assign clear_evt = !gate_sel && clr_en && edge_hit(prev_q, lvl, edge_sel);
  assign gate_ok   = !gate_sel || gate_open(lvl, edge_sel);
endmodule

// File: rtl/rut_count_core.sv
module rut_count_core
  import rut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec,
  input  logic             sw_load,
  input  logic             sw_clear,
  input  logic             ext_clear,
  input  logic             rld_en,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             uf_evt
);
  logic [CNT_W:0] step;
  logic           override;

  assign step     = count_step(count, reload, rld_en);
  assign override = sw_load || sw_clear || ext_clear;
  assign uf_evt   = dec && !override && step[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= '0;
    else if (sw_load)   count <= reload;
    else if (sw_clear)  count <= '0;
    else if (ext_clear) count <= '0;
    else if (dec)       count <= step[CNT_W-1:0];
  end
endmodule

// File: rtl/rut_regs.sv
module rut_regs
  import rut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              uf_evt,
  input  logic              rev_evt,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [CNT_W-1:0]  reload,
  output logic              run_bit,
  output logic              uf_flag,
  output logic              slow,
  output logic [1:0]        mode,
  output logic              gate_sel,
  output logic              xclr_en,
  output logic [1:0]        edge_sel,
  output logic              rld_en,
  output logic              sw_load,
  output logic              sw_clear,
  output logic              irq
);
  logic [CNT_W-1:0] ctrl_q;
  logic             rev_flag;
  logic             uf_ie;
  logic             wr_ctrl, wr_stat, wr_lo, wr_hi;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_lo   = bus_wr && (bus_addr == A_RLD_LO);
  assign wr_hi   = bus_wr && (bus_addr == A_RLD_HI);

  assign sw_load  = wr_ctrl && bus_wdata[C_LOAD];
  assign sw_clear = wr_ctrl && !bus_wdata[C_CLR_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      rev_flag <= 1'b0;
      run_bit  <= 1'b0;
      uf_ie    <= 1'b0;
      uf_flag  <= 1'b0;
      reload   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (rev_evt)                                 rev_flag <= 1'b1;
      else if (wr_ctrl && !bus_wdata[C_REV_FLAG])  rev_flag <= 1'b0;
      if (wr_stat) begin
        run_bit <= bus_wdata[S_RUN];
        uf_ie   <= bus_wdata[S_UF_IE];
      end
      if (uf_evt)                           uf_flag <= 1'b1;
      else if (wr_stat && !bus_wdata[S_UF]) uf_flag <= 1'b0;
      if (wr_lo) reload[HALF_W-1:0]     <= bus_wdata[HALF_W-1:0];
      if (wr_hi) reload[CNT_W-1:HALF_W] <= bus_wdata[HALF_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata             = ctrl_q;
        bus_rdata[C_REV_FLAG] = rev_flag;
        bus_rdata[C_CLR_N]    = 1'b1;
      end
      A_STAT: begin
        bus_rdata[S_RUN]   = run_bit;
        bus_rdata[S_UF_IE] = uf_ie;
        bus_rdata[S_UF]    = uf_flag;
      end
      A_RLD_LO: bus_rdata[HALF_W-1:0] = reload[HALF_W-1:0];
      A_RLD_HI: bus_rdata[HALF_W-1:0] = reload[CNT_W-1:HALF_W];
      A_COUNT:  bus_rdata = count;
      default:  bus_rdata = '0;
    endcase
  end

  assign slow     = ctrl_q[C_CLK_SLOW];
  assign mode     = ctrl_q[C_MODE_LO +: 2];
  assign gate_sel = ctrl_q[C_GATE_SEL];
  assign xclr_en  = ctrl_q[C_XCLR_EN];
  assign edge_sel = ctrl_q[C_EDGE_LO +: 2];
  assign rld_en   = ctrl_q[C_RLD_EN];

  assign irq = (uf_flag && uf_ie) || (rev_flag && ctrl_q[C_REV_IE]);
endmodule

// File: rtl/reload_updown_timer.sv
module reload_updown_timer
  import rut_pkg::*;
#(
  parameter int SLOW_DIV = 8,
  parameter int FAST_DIV = 2,
  parameter int SYNC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_in,
  output logic              irq
);
  // named internal events, also watched by the checker
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reload;
  logic             run_bit, run, tick, dec;
  logic             uf_flag, uf_evt;
  logic             slow, gate_sel, xclr_en, rld_en;
  logic [1:0]       mode, edge_sel;
  logic             sw_load, sw_clear, ext_clear, gate_ok;

  rut_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count(count), .uf_evt(uf_evt),
    .rev_evt(1'b0),  // a down-only timer never reverses direction
    .bus_rdata(bus_rdata), .reload(reload), .run_bit(run_bit),
    .uf_flag(uf_flag), .slow(slow), .mode(mode), .gate_sel(gate_sel),
    .xclr_en(xclr_en), .edge_sel(edge_sel), .rld_en(rld_en),
    .sw_load(sw_load), .sw_clear(sw_clear), .irq(irq)
  );

  assign run = run_bit && (mode == 2'b00);

  rut_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .slow(slow), .tick(tick)
  );

  rut_ext_input #(.SYNC(SYNC)) u_ext (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .gate_sel(gate_sel),
    .clr_en(xclr_en), .edge_sel(edge_sel), .clear_evt(ext_clear),
    .gate_ok(gate_ok)
  );

  assign dec = tick && gate_ok;

  rut_count_core u_core (
    .clk(clk), .rst_n(rst_n), .dec(dec), .sw_load(sw_load),
    .sw_clear(sw_clear), .ext_clear(ext_clear), .rld_en(rld_en),
    .reload(reload), .count(count), .uf_evt(uf_evt)
  );
endmodule

// File: rtl/rut_checker.sv
module rut_checker
  import rut_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             dec,
  input logic             sw_load,
  input logic             sw_clear,
  input logic             ext_clear,
  input logic             uf_evt,
  input logic             run,
  input logic             rld_en,
  input logic             uf_flag,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload
);
  // R3
  uf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> count == $past(rld_en ? reload : {CNT_W{1'b1}}));

  // R3
  uf_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> uf_flag);

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !sw_load && !sw_clear && !ext_clear && count != '0)
      |=> count == $past(count) - CNT_W'(1));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R5
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> count == $past(reload));

  // R6
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && !sw_load) |=> count == '0);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_load && !sw_clear && !ext_clear) |=> $stable(count));
endmodule

bind reload_updown_timer rut_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .dec(dec), .sw_load(sw_load),
  .sw_clear(sw_clear), .ext_clear(ext_clear), .uf_evt(uf_evt), .run(run),
  .rld_en(rld_en), .uf_flag(uf_flag), .count(count), .reload(reload)
);

// File: tb/reload_updown_timer_tb.sv
`timescale 1ns/1ps
module reload_updown_timer_tb;
  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, LO = 3'd2, HI = 3'd3, CNT = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_in = 1'b0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  reload_updown_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write captured on the next rising edge; returns 1 ns after it
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] mk_ctrl(input logic slow, input logic rld_en,
      input logic gsel, input logic xclr, input logic [1:0] edg, input logic [1:0] mode);
    return (16'(slow) << 12) | (16'(mode) << 10) | (16'(xclr) << 5) |
           (16'(rld_en) << 4) | 16'h0008 | (16'(gsel) << 2) | 16'(edg);
  endfunction

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] got;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(CTRL, got); check("R1 ctrl", got, 16'h0008);
    rd(STAT, got); check("R1 stat", got, 16'h0000);
    idle(1);
    rd(CNT, got);  check("R1 count", got, 16'h0000);
    rd(LO, got);   check("R1 reload", got, 16'h0000);
    check("R1 irq", 16'(irq), 16'h0000);

    // R4 byte-wise reload
    wr(LO, 16'hFFAB); wr(HI, 16'h12CD);
    rd(LO, got); check("R4 low byte", got, 16'h00AB);
    rd(HI, got); check("R4 high byte", got, 16'h00CD);

    // R5 / R6 strobes with counter stopped
    wr(CTRL, 16'h0048);
    rd(CNT, got); check("R5 load copies reload", got, 16'hCDAB);
    wr(CTRL, 16'h0008);
    rd(CNT, got); check("R5 bit6=0 no effect", got, 16'hCDAB);
    wr(CTRL, 16'h0000);
    rd(CNT, got); check("R6 clear strobe", got, 16'h0000);
    wr(CTRL, 16'h0040);
    rd(CNT, got); check("R6 load beats clear", got, 16'hCDAB);
    rd(CTRL, got); check("R6 strobe bits read", got, 16'h0008);

    // R12 storage bits; R7 bit14 write 1 does not set
    wr(CTRL, 16'hFFFF);
    rd(CTRL, got); check("R12 R7 ctrl readback", got, 16'hBFBF);
    wr(CTRL, 16'h0008);

    // R11 non-timer mode and stopped hold
    wr(CTRL, mk_ctrl(0, 0, 0, 0, 2'b00, 2'b01));
    wr(STAT, 16'h0080);
    idle(20);
    rd(CNT, got); check("R11 non-timer hold", got, 16'hCDAB);
    wr(STAT, 16'h0000);
    wr(CTRL, mk_ctrl(0, 0, 0, 0, 2'b00, 2'b00));
    idle(20);
    rd(CNT, got); check("R11 stopped hold", got, 16'hCDAB);

    // R2 R3 R8 sweep
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 2; e++)
        for (int v = 0; v < 4; v++)
          for (int n = 1; n <= 6; n++) begin
            logic [15:0] c, st, ctl;
            logic uf, ie;
            int dv;
            dv = (s != 0) ? 8 : 2;
            ie = n[0];
            ctl = mk_ctrl(s[0], e[0], 0, 0, 2'b00, 2'b00);
            wr(STAT, 16'h0000); wr(STAT, 16'h0000);
            wr(LO, 16'(v)); wr(HI, 16'h0000); wr(CTRL, ctl | 16'h0040);
            wr(LO, 16'h005A); wr(HI, 16'h0001); wr(CTRL, ctl);
            wr(STAT, 16'h0084 | (16'(ie) << 5));
            repeat (n * dv) @(posedge clk);
            #1;
            c = 16'(v); uf = 1'b0;
            for (int i = 0; i < n; i++) begin
              if (c == 16'h0000) begin
                c = (e != 0) ? 16'h015A : 16'hFFFF;
                uf = 1'b1;
              end else c = c - 16'h0001;
            end
            rd(CNT, got); check("R2 R3 sweep count", got, c);
            rd(STAT, st);
            check("R3 R7 sweep status", st, 16'h0080 | (16'(ie) << 5) | (16'(uf) << 2));
            check("R8 sweep irq", 16'(irq), 16'(uf & ie));
          end

    // R7 flag: write 1 keeps, write 0 clears, set wins over clear
    wr(STAT, 16'h0000); wr(STAT, 16'h0000);
    wr(LO, 16'h0003); wr(HI, 16'h0000);
    wr(CTRL, mk_ctrl(0, 1, 0, 0, 2'b00, 2'b00) & 16'hFFF7);
    wr(CTRL, mk_ctrl(0, 1, 0, 0, 2'b00, 2'b00));
    wr(STAT, 16'h00A0);
    @(posedge clk); #1;
    wr(STAT, 16'h00A0);
    rd(STAT, got); check("R7 set wins over clear", got, 16'h00A4);
    check("R8 irq with flag", 16'(irq), 16'h0001);
    wr(STAT, 16'h0024);
    rd(STAT, got); check("R7 write 1 keeps flag", got, 16'h0024);
    wr(STAT, 16'h0020);
    rd(STAT, got); check("R7 write 0 clears flag", got, 16'h0020);
    check("R8 irq after clear", 16'(irq), 16'h0000);
    wr(STAT, 16'h0000);

    // R9 external clear, per edge code and direction
    wr(LO, 16'h0034); wr(HI, 16'h0012);
    for (int sel = 0; sel < 4; sel++)
      for (int dir = 0; dir < 2; dir++) begin
        logic expect_clr;
        wr(CTRL, mk_ctrl(0, 0, 0, 0, 2'(sel), 2'b00));
        ext_in = (dir == 0) ? 1'b0 : 1'b1;
        idle(5);
        wr(CTRL, mk_ctrl(0, 0, 0, 1, 2'(sel), 2'b00) | 16'h0040);
        ext_in = ~ext_in;
        idle(5);
        expect_clr = (sel == 3) || (sel == 1 && dir == 0) || (sel == 2 && dir == 1);
        rd(CNT, got);
        check("R9 ext clear", got, expect_clr ? 16'h0000 : 16'h1234);
      end
    wr(CTRL, mk_ctrl(0, 0, 0, 0, 2'b11, 2'b00) | 16'h0040);
    ext_in = ~ext_in;
    idle(5);
    rd(CNT, got); check("R9 clear needs bit5", got, 16'h1234);

    // R10 gating
    wr(LO, 16'h0000); wr(HI, 16'h0001);
    for (int sel = 0; sel < 4; sel++)
      for (int lv = 0; lv < 2; lv++) begin
        logic open;
        wr(STAT, 16'h0000);
        wr(CTRL, mk_ctrl(0, 0, 1, 0, 2'(sel), 2'b00) | 16'h0040);
        ext_in = lv[0];
        idle(5);
        wr(STAT, 16'h0080);
        idle(6);
        open = (sel == 1) ? lv[0] : (sel == 2) ? !lv[0] : 1'b1;
        rd(CNT, got);
        check("R10 gate", got, open ? 16'h00FD : 16'h0100);
      end
    wr(STAT, 16'h0000);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule